// File: doc/BRIEF.md
# Interrupt Request Router for Transfer Engine and CPU

This block receives N pending interrupt requests from peripherals and sends each one to one of two consumers. A per-source routing bit selects the consumer. When the bit is set, the request is an activation request for the data-transfer controller. When the bit is clear, it is an interrupt request for the CPU. Each consumer gets a registered vector number, which is the index of the source, together with a strobe that stays high until that consumer acknowledges it. After a request has been serviced, the block sends a one-cycle clear pulse back to the peripheral that raised it.

The two paths arbitrate differently. The transfer path uses a fixed order in which the lowest index wins, and it ignores all priority levels and the mask. The CPU path picks the highest effective priority and breaks ties by the lowest index. It forwards the winner only when that priority is strictly above the CPU mask. The effective priority is either a per-source field or a single global level, depending on a mode input.

When the transfer engine acknowledges a transfer, it also reports whether a CPU interrupt was selected for that transfer or whether its transfer count has reached zero. If either is reported, the routing bit is cleared in hardware. No clear pulse is sent in that case. The request therefore stays pending and is passed to the CPU.

Top module: `irq_router`

## Requirements
- R1: A pending source whose routing bit is 1 is offered only to the transfer path, on `dtc_req` with `dtc_vec` = its index. A pending source whose routing bit is 0 is offered only to the CPU path.
- R2: Among pending transfer-routed sources, the lowest index wins. `cpu_mask`, `pri_mode`, `src_pri` and `cpu_gpri` have no effect on this choice.
- R3: An acknowledge of the transfer strobe with `dtc_chain`=0 and `dtc_cnt_zero`=0 drives `irq_clr` bit [vec] high for exactly the one cycle after the acknowledge edge. The routing bit is left unchanged.
- R4: An acknowledge with `dtc_chain`=1 clears the routing bit of the serviced source and sends no clear pulse. The still-pending source is then requested on the CPU path.
- R5: An acknowledge with `dtc_cnt_zero`=1 behaves like R4.
- R6: The CPU winner is the source with the highest effective priority. On equal priority, the lowest index wins.
- R7: With `pri_mode`=1, the effective priority of source i is `src_pri[3i+2:3i]`. With `pri_mode`=0, every source uses `cpu_gpri`.
- R8: `cpu_req` is raised only when the winner's priority is strictly greater than `cpu_mask`. When the mask is lowered, a request that was held back is launched.
- R9: A source with its routing bit set never appears on `cpu_vec`.
- R10: Vectors are registered. A strobe that is not acknowledged holds its vector. A strobe falls in the cycle after its acknowledge.
- R11: A CPU acknowledge drives `irq_clr` bit [`cpu_vec`] high for the following cycle.
- R12: When a software write to the routing bits and a hardware clear land in the same cycle, the hardware clear wins for the serviced bit. All other bits take the written value.
- R13: After reset, `irq_clr`, `route_state`, `dtc_req`, `dtc_vec`, `cpu_req` and `cpu_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_SRC | Pending request level from each peripheral |
| irq_clr | output | N_SRC | One-cycle clear pulse to each peripheral |
| route_wr | input | 1 | Write strobe for the routing bits |
| route_wdata | input | N_SRC | New routing bits (1 = transfer engine) |
| route_state | output | N_SRC | Current routing bits |
| pri_mode | input | 1 | 1 = per-source priorities, 0 = global priority |
| src_pri | input | N_SRC*PRI_W | Per-source priority fields, source i at [PRI_W*i +: PRI_W] |
| cpu_gpri | input | PRI_W | Global CPU priority |
| cpu_mask | input | PRI_W | CPU mask level |
| dtc_req | output | 1 | Activation strobe to the transfer engine |
| dtc_vec | output | IW | Source index of the activation |
| dtc_ack | input | 1 | Transfer finished for `dtc_vec` |
| dtc_chain | input | 1 | CPU interrupt selected for this transfer (valid with ack) |
| dtc_cnt_zero | input | 1 | Transfer count reached zero (valid with ack) |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | IW | Source index of the CPU request |
| cpu_ack | input | 1 | CPU accepted `cpu_vec` |

## Verification
The transfer-completion path and the CPU-acknowledge path can act in the same cycle. Both write the clear-pulse register, and a hand-over can also meet a software write to the routing bits. The bench provokes these collisions directly: it acknowledges both strobes on the same edge, with and without a hand-over, and it writes all-ones to the routing bits on the hand-over edge. It then judges the merged clear-pulse pattern, the final routing bits and the next pair of winners against values computed from the requirements. Random scenarios acknowledge both strobes together whenever both are up, so this overlap is exercised across many source mixes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic {
    PRI_GLOBAL  = 1'b0,
    PRI_PER_SRC = 1'b1
  } pri_mode_e;

  // A completed transfer hands the source to the CPU when either flag is set.
  function automatic logic completes_to_cpu(input logic chain, input logic cnt_zero);
    return chain | cnt_zero;
  endfunction

endpackage

// File: rtl/irq_fixed_arb.sv
module irq_fixed_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Lowest set index wins; scan downward so the last hit is the lowest.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int PW = 3
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] pri,
  output logic            any,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   best
);
  // Strictly-greater replace keeps the lowest index on equal levels.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!any || (pri[i*PW +: PW] > best))) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = pri[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_route_reg.sv
module irq_route_reg #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [N-1:0]  wdata,
  input  logic          hw_clr_en,
  input  logic [IW-1:0] hw_clr_idx,
  output logic [N-1:0]  route_q
);
  logic [N-1:0] after_wr;
  logic [N-1:0] clr_mask;

  always_comb begin
    after_wr = wr ? wdata : route_q;
    clr_mask = hw_clr_en ? (N'(1) << hw_clr_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) route_q <= '0;
    else     route_q <= after_wr & ~clr_mask;
  end

  // R12: hardware clear beats a same-cycle software write
  p_hw_clear_wins_r12: assert property (@(posedge clk) disable iff (rst)
    hw_clr_en |=> !route_q[$past(hw_clr_idx)]);

endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_SRC = 8,
  parameter int PRI_W = 3,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   irq_req,
  output logic [N_SRC-1:0]   irq_clr,
  input  logic               route_wr,
  input  logic [N_SRC-1:0]   route_wdata,
  output logic [N_SRC-1:0]   route_state,
  input  logic               pri_mode,
  input  logic [N_SRC*PRI_W-1:0] src_pri,
  input  logic [PRI_W-1:0]   cpu_gpri,
  input  logic [PRI_W-1:0]   cpu_mask,
  output logic               dtc_req,
  output logic [IW-1:0]      dtc_vec,
  input  logic               dtc_ack,
  input  logic               dtc_chain,
  input  logic               dtc_cnt_zero,
  output logic               cpu_req,
  output logic [IW-1:0]      cpu_vec,
  input  logic               cpu_ack
);
  import irq_router_pkg::*;

  logic [N_SRC-1:0]       route_q;
  logic [N_SRC-1:0]       clr_q;
  logic [N_SRC-1:0]       dtc_cand;
  logic [N_SRC-1:0]       cpu_cand;
  logic [N_SRC*PRI_W-1:0] eff_pri;
  pri_mode_e              mode;

  logic                   dtc_any;
  logic [IW-1:0]          dtc_idx;
  logic                   cpu_any;
  logic [IW-1:0]          cpu_idx;
  logic [PRI_W-1:0]       cpu_best;

  logic                   dtc_req_q, cpu_req_q;
  logic [IW-1:0]          dtc_vec_q, cpu_vec_q;
  logic                   dtc_done, cpu_done, handover, cpu_fire;

  assign mode = pri_mode_e'(pri_mode);

  // Sources whose clear pulse is in flight are withheld from both paths.
  always_comb begin
    dtc_cand = irq_req &  route_q & ~clr_q;
    cpu_cand = irq_req & ~route_q & ~clr_q;
  end

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_eff
      assign eff_pri[g*PRI_W +: PRI_W] =
        (mode == PRI_PER_SRC) ? src_pri[g*PRI_W +: PRI_W] : cpu_gpri;
    end
  endgenerate

  irq_fixed_arb #(.N(N_SRC), .IW(IW)) u_dtc_arb (
    .req (dtc_cand),
    .any (dtc_any),
    .idx (dtc_idx)
  );

  irq_level_arb #(.N(N_SRC), .IW(IW), .PW(PRI_W)) u_cpu_arb (
    .req  (cpu_cand),
    .pri  (eff_pri),
    .any  (cpu_any),
    .idx  (cpu_idx),
    .best (cpu_best)
  );

  always_comb begin
    dtc_done = dtc_req_q & dtc_ack;
    cpu_done = cpu_req_q & cpu_ack;
    handover = dtc_done & completes_to_cpu(dtc_chain, dtc_cnt_zero);
    cpu_fire = cpu_any && (cpu_best > cpu_mask);
  end

  irq_route_reg #(.N(N_SRC), .IW(IW)) u_route (
    .clk        (clk),
    .rst        (rst),
    .wr         (route_wr),
    .wdata      (route_wdata),
    .hw_clr_en  (handover),
    .hw_clr_idx (dtc_vec_q),
    .route_q    (route_q)
  );

  // Transfer-engine strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      dtc_req_q <= 1'b0;
      dtc_vec_q <= '0;
    end else if (dtc_req_q) begin
      if (dtc_ack) dtc_req_q <= 1'b0;
    end else if (dtc_any) begin
      dtc_req_q <= 1'b1;
      dtc_vec_q <= dtc_idx;
    end
  end

  // CPU strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_req_q <= 1'b0;
      cpu_vec_q <= '0;
    end else if (cpu_req_q) begin
      if (cpu_ack) cpu_req_q <= 1'b0;
    end else if (cpu_fire) begin
      cpu_req_q <= 1'b1;
      cpu_vec_q <= cpu_idx;
    end
  end

  // Clear pulses: released transfers and CPU acknowledges may merge.
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q <= '0;
    end else begin
      clr_q <= ((dtc_done && !handover) ? (N_SRC'(1) << dtc_vec_q) : '0)
             | (cpu_done ? (N_SRC'(1) << cpu_vec_q) : '0);
    end
  end

  assign irq_clr     = clr_q;
  assign route_state = route_q;
  assign dtc_req     = dtc_req_q;
  assign dtc_vec     = dtc_vec_q;
  assign cpu_req     = cpu_req_q;
  assign cpu_vec     = cpu_vec_q;

  // R10: strobes fall after acknowledge and hold otherwise
  p_dtc_drop_r10: assert property (@(posedge clk) disable iff (rst)
    dtc_req && dtc_ack |=> !dtc_req);
  p_cpu_drop_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_ack |=> !cpu_req);
  p_dtc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    dtc_req && !dtc_ack |=> dtc_req && $stable(dtc_vec));
  p_cpu_hold_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_ack |=> cpu_req && $stable(cpu_vec));
  // R8: a launched CPU request beat the mask
  p_cpu_above_mask_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_req) |-> ($past(cpu_best) > $past(cpu_mask)));
  // R3: plain completion pulses the serviced source
  p_release_clr_r3: assert property (@(posedge clk) disable iff (rst)
    dtc_req && dtc_ack && !dtc_chain && !dtc_cnt_zero |=> irq_clr[$past(dtc_vec)]);
  // R4: hand-over sends no pulse unless the CPU also finished
  p_handover_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    handover && !cpu_done |=> irq_clr == '0);
  // R11: CPU acknowledge pulses its source
  p_cpu_clr_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_ack |=> irq_clr[$past(cpu_vec)]);

endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]    raise = '0;
  logic [N-1:0]    pend;
  logic [N-1:0]    irq_clr, route_state;
  logic            route_wr = 1'b0;
  logic [N-1:0]    route_wdata = '0;
  logic            pri_mode = 1'b0;
  logic [N*PW-1:0] src_pri = '0;
  logic [PW-1:0]   cpu_gpri = '0, cpu_mask = '0;
  logic            dtc_req, cpu_req;
  logic [IW-1:0]   dtc_vec, cpu_vec;
  logic            dtc_ack = 1'b0, dtc_chain = 1'b0, dtc_cnt_zero = 1'b0, cpu_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Peripheral model: request held until its clear pulse
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~irq_clr) | raise;
  end

  irq_router u_irq_router (
    .clk(clk), .rst(rst), .irq_req(pend), .irq_clr(irq_clr),
    .route_wr(route_wr), .route_wdata(route_wdata), .route_state(route_state),
    .pri_mode(pri_mode), .src_pri(src_pri), .cpu_gpri(cpu_gpri), .cpu_mask(cpu_mask),
    .dtc_req(dtc_req), .dtc_vec(dtc_vec), .dtc_ack(dtc_ack),
    .dtc_chain(dtc_chain), .dtc_cnt_zero(dtc_cnt_zero),
    .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_dtc(input logic [N-1:0] p, input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (p[i] && r[i]) return i;
    return -1;
  endfunction

  function automatic int exp_cpu(input logic [N-1:0] p, input logic [N-1:0] r,
                                 input logic m, input logic [N*PW-1:0] pr,
                                 input logic [PW-1:0] g, input logic [PW-1:0] mk);
    int best = -1;
    int who  = -1;
    for (int i = 0; i < N; i++) begin
      int lv = m ? int'(pr[i*PW +: PW]) : int'(g);
      if (p[i] && !r[i] && lv > best) begin best = lv; who = i; end
    end
    if (who >= 0 && best > int'(mk)) return who;
    return -1;
  endfunction

  task automatic setup(input logic [N-1:0] rt, input logic m, input logic [N*PW-1:0] pr,
                       input logic [PW-1:0] g, input logic [PW-1:0] mk, input logic [N-1:0] rv);
    rst = 1'b1; dtc_ack = 0; cpu_ack = 0; dtc_chain = 0; dtc_cnt_zero = 0;
    raise = '0; route_wr = 0;
    step(); step();
    rst = 1'b0;
    pri_mode = m; src_pri = pr; cpu_gpri = g; cpu_mask = mk;
    route_wr = 1'b1; route_wdata = rt;
    step();
    route_wr = 1'b0; raise = rv;
    step();
    raise = '0;
    step();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N*PW-1:0] pr;
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 irq_clr", int'(irq_clr), 0);
    chk("R13 route", int'(route_state), 0);
    chk("R13 dtc_req", int'(dtc_req), 0);
    chk("R13 cpu_req", int'(cpu_req), 0);
    chk("R13 vecs", int'(dtc_vec) + int'(cpu_vec), 0);

    // R2 fixed order ignores mask and levels; R10 hold; R3 release pulse
    pr = '0; pr[7*PW +: PW] = 3'd7;
    setup(8'hFF, 1'b1, pr, 3'd7, 3'd7, 8'b1011_0100);
    chk("R2 dtc_req", int'(dtc_req), 1);
    chk("R2 dtc_vec", int'(dtc_vec), 2);
    chk("R9 cpu idle all routed", int'(cpu_req), 0);
    step(); step(); step();
    chk("R10 hold req", int'(dtc_req), 1);
    chk("R10 hold vec", int'(dtc_vec), 2);
    dtc_ack = 1;
    step();
    dtc_ack = 0;
    chk("R10 dtc drop", int'(dtc_req), 0);
    chk("R3 clr pulse", int'(irq_clr), 1 << 2);
    chk("R3 route kept", int'(route_state), 8'hFF);
    step();
    chk("R3 pulse one wide", int'(irq_clr), 0);
    chk("R2 next winner", int'(dtc_vec), 4);
    chk("R1 next req", int'(dtc_req), 1);

    // R4 chain hand-over, R11 CPU clear
    setup(8'h20, 1'b0, '0, 3'd1, 3'd0, 8'h20);
    chk("R1 dtc vec 5", int'(dtc_vec), 5);
    chk("R9 no cpu", int'(cpu_req), 0);
    dtc_ack = 1; dtc_chain = 1;
    step();
    dtc_ack = 0; dtc_chain = 0;
    chk("R4 route cleared", int'(route_state), 0);
    chk("R4 no pulse", int'(irq_clr), 0);
    step();
    chk("R4 cpu req", int'(cpu_req), 1);
    chk("R4 cpu vec", int'(cpu_vec), 5);
    cpu_ack = 1;
    step();
    cpu_ack = 0;
    chk("R10 cpu drop", int'(cpu_req), 0);
    chk("R11 cpu clr", int'(irq_clr), 1 << 5);
    step();
    chk("R11 pulse gone", int'(irq_clr), 0);
    chk("R11 no relaunch", int'(cpu_req), 0);

    // R5 count reaches zero
    setup(8'h02, 1'b0, '0, 3'd2, 3'd1, 8'h02);
    dtc_ack = 1; dtc_cnt_zero = 1;
    step();
    dtc_ack = 0; dtc_cnt_zero = 0;
    chk("R5 route cleared", int'(route_state), 0);
    chk("R5 no pulse", int'(irq_clr), 0);
    step();
    chk("R5 cpu req", int'(cpu_req), 1);
    chk("R5 cpu vec", int'(cpu_vec), 1);

    // R8 strict compare against the mask, then lowered mask
    setup(8'h00, 1'b0, '0, 3'd3, 3'd3, 8'h11);
    chk("R8 equal blocked", int'(cpu_req), 0);
    cpu_mask = 3'd2;
    step();
    chk("R8 launched", int'(cpu_req), 1);
    chk("R6 tie lowest", int'(cpu_vec), 0);

    // R7 / R6 per-source levels versus global
    pr = '0; pr[0 +: PW] = 3'd2; pr[3*PW +: PW] = 3'd5; pr[6*PW +: PW] = 3'd5;
    setup(8'h00, 1'b1, pr, 3'd7, 3'd1, 8'b0100_1001);
    chk("R7 per-source winner", int'(cpu_vec), 3);
    setup(8'h00, 1'b0, pr, 3'd1, 3'd0, 8'b0100_1001);
    chk("R7 global winner", int'(cpu_vec), 0);

    // R12 software write on the hand-over edge
    setup(8'h10, 1'b0, '0, 3'd0, 3'd7, 8'h10);
    dtc_ack = 1; dtc_chain = 1; route_wr = 1; route_wdata = 8'hFF;
    step();
    dtc_ack = 0; dtc_chain = 0; route_wr = 0;
    chk("R12 hw clear wins", int'(route_state), 8'hEF);

    // Collision: both acknowledges on one edge (R3, R11)
    setup(8'h04, 1'b0, '0, 3'd4, 3'd0, 8'h44);
    chk("R1 dtc 2", int'(dtc_vec), 2);
    chk("R1 cpu 6", int'(cpu_vec), 6);
    dtc_ack = 1; cpu_ack = 1;
    step();
    dtc_ack = 0; cpu_ack = 0;
    chk("R3 R11 merged clr", int'(irq_clr), 8'h44);

    // Random scenarios
    void'($urandom(32'h1234_5678));
    for (int it = 0; it < 300; it++) begin
      logic [N-1:0] rt, rv, ep, eclr, eroute;
      logic m, ho;
      logic [PW-1:0] g, mk;
      int dv, cv;
      rt = N'($urandom); rv = N'($urandom); m = 1'($urandom);
      pr = (N*PW)'($urandom); g = PW'($urandom); mk = PW'($urandom);
      setup(rt, m, pr, g, mk, rv);
      ep = rv;
      dv = exp_dtc(ep, rt);
      cv = exp_cpu(ep, rt, m, pr, g, mk);
      chk("R1 R2 rnd dtc_req", int'(dtc_req), int'(dv >= 0));
      if (dv >= 0) chk("R2 rnd dtc_vec", int'(dtc_vec), dv);
      chk("R6 R8 rnd cpu_req", int'(cpu_req), int'(cv >= 0));
      if (cv >= 0) chk("R6 R7 rnd cpu_vec", int'(cpu_vec), cv);
      ho = 1'b0;
      if (dv >= 0) begin
        dtc_ack = 1; dtc_chain = 1'($urandom); dtc_cnt_zero = (($urandom % 4) == 0);
        ho = dtc_chain | dtc_cnt_zero;
      end
      if (cv >= 0) cpu_ack = 1;
      step();
      dtc_ack = 0; cpu_ack = 0; dtc_chain = 0; dtc_cnt_zero = 0;
      eclr = '0;
      if (dv >= 0 && !ho) eclr |= N'(1) << dv;
      if (cv >= 0) eclr |= N'(1) << cv;
      eroute = rt;
      if (dv >= 0 && ho) eroute &= ~(N'(1) << dv);
      chk("R10 rnd dtc drop", int'(dtc_req), 0);
      chk("R10 rnd cpu drop", int'(cpu_req), 0);
      chk("R3 R11 rnd clr", int'(irq_clr), int'(eclr));
      chk("R4 R5 rnd route", int'(route_state), int'(eroute));
      step();
      ep = ep & ~eclr;
      dv = exp_dtc(ep, eroute);
      cv = exp_cpu(ep, eroute, m, pr, g, mk);
      chk("R4 rnd next dtc", int'(dtc_req), int'(dv >= 0));
      if (dv >= 0) chk("R2 rnd next dtc_vec", int'(dtc_vec), dv);
      chk("R4 R9 rnd next cpu", int'(cpu_req), int'(cv >= 0));
      if (cv >= 0) chk("R6 rnd next cpu_vec", int'(cpu_vec), cv);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule